// File: doc/BRIEF.md
# Security Access State Tracker

This block holds the session security state that decides whether each of four user memory zones may be read or written. Verification engines outside the block compare passwords, run the authentication exchange and recompute message authentication codes. The engines deliver only pass or fail pulses here, each tagged with the password set or key it concerns. The tracker remembers one password credential and one authenticated key, and moves the link between standard, authenticated and encrypted modes. It counts consecutive failures per credential and locks a credential that fails too often.

Each zone carries a configuration byte that names the password set and the key it depends on. The byte also says whether a password, an authentication or encryption is demanded. From these bytes and the held state the block drives one read grant and one write grant per zone. A power-on reset clears everything, including the failure counters, which stand in for nonvolatile storage. A separate session reset clears only the session: the held password, the authentication and the mode.

Top module: `sec_access_tracker`

## Requirements
- R1: After power-on reset `por` the mode output is standard (0), no password or key is held, no lock flag is set, and only zones whose configuration demands nothing report grants.
- R2: A passing password verdict for set S makes S the single held password and replaces any earlier one. A failing verdict on an unlocked set drops the held password.
- R3: A held write password (`pw_wr`=1) grants read and write on zones bound to its set. A held read password grants read only. No zone ever has a write grant without a read grant.
- R4: A passing authentication for key K sets the mode to authenticated (1) and records K. A failing authentication on an unlocked key returns the mode to standard and forgets the earlier authentication.
- R5: An encryption request moves the mode from authenticated to encrypted (2). In standard mode the request is ignored. An authentication verdict in the same cycle takes precedence over the request.
- R6: A MAC failure pulse in authenticated or encrypted mode returns the mode to standard, forgets the authentication, and discards every credential verdict of that cycle. In standard mode the pulse has no effect.
- R7: Session reset `sess_rst` clears the held password, the authentication and the mode, and discards every other pulse in that cycle. It leaves the failure counters and lock flags unchanged.
- R8: After four consecutive failing verdicts on a password set or key, its lock flag is set. Until power-on reset, further verdicts on that credential change neither the held state nor the mode.
- R9: A passing verdict on an unlocked credential clears its consecutive-failure count.
- R10: Zone z's configuration is byte z of `zone_cfg`: bit 7 requires a password, bits 6:4 give the set, bit 3 requires authentication, bit 2 requires encryption, bits 1:0 give the key. Authentication is met when the mode is not standard and the recorded key matches. Read and write grants are the AND of the requirements.
- R11: A zone with bit 2 set reports no grant unless the mode is encrypted and the recorded key equals the zone's key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears all state |
| sess_rst | input | 1 | Session reset pulse |
| pw_vld | input | 1 | Password verdict pulse |
| pw_pass | input | 1 | Password verdict result (1 = match) |
| pw_wr | input | 1 | Verdict concerns the write password of the set |
| pw_set | input | 3 | Password set index |
| au_vld | input | 1 | Authentication verdict pulse |
| au_pass | input | 1 | Authentication result (1 = success) |
| au_key | input | 2 | Key index |
| enc_req | input | 1 | Encryption activation request pulse |
| mac_fail | input | 1 | MAC mismatch pulse on an incoming command |
| zone_cfg | input | 32 | Per-zone configuration bytes |
| rd_grant | output | 4 | Read grant per zone |
| wr_grant | output | 4 | Write grant per zone |
| mode | output | 2 | 0 standard, 1 authenticated, 2 encrypted |
| pw_locked | output | 8 | Lock flag per password set |
| key_locked | output | 4 | Lock flag per key |

## Verification
A MAC failure or a session reset can land in the same cycle as a credential verdict or an encryption request. The priority among them decides which state survives. The bench pulses an authentication success together with a MAC failure, once in standard mode and once in authenticated mode, and a write-password success together with a session reset. It then reads the mode and per-zone grants in the next cycle. In standard mode the verdict must take effect; otherwise the higher-priority event must leave no trace of it. A case pairing an authentication with an encryption request checks that the mode stops at authenticated.

// File: rtl/sec_pkg.sv
package sec_pkg;

    localparam int ZONES      = 4;
    localparam int PW_SETS    = 8;
    localparam int KEYS       = 4;
    localparam int FAIL_LIMIT = 4;

    localparam int PW_W  = $clog2(PW_SETS);
    localparam int KEY_W = $clog2(KEYS);
    localparam int CFG_W = 3 + PW_W + KEY_W;

    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_AUTH = 2'd1,
        MODE_ENC  = 2'd2
    } mode_e;

    typedef struct packed {
        logic             pw_en;
        logic [PW_W-1:0]  pw_idx;
        logic             au_en;
        logic             enc_en;
        logic [KEY_W-1:0] key_idx;
    } zone_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [PW_W-1:0]  set;
        logic             wr;
    } pw_state_t;

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] key;
    } au_state_t;

    function automatic zone_cfg_t cfg_slice(logic [ZONES*CFG_W-1:0] all, int z);
        return zone_cfg_t'(all[z*CFG_W +: CFG_W]);
    endfunction

    function automatic logic mode_secure(mode_e m);
        return (m == MODE_AUTH) || (m == MODE_ENC);
    endfunction

endpackage

// File: rtl/sec_fail_ctr.sv
module sec_fail_ctr #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic por,
    input  logic hit_pass,
    input  logic hit_fail,
    output logic locked
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (por) begin
            cnt <= '0;
        end else if (hit_pass) begin
            cnt <= '0;
        end else if (hit_fail && (cnt < CW'(LIMIT))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign locked = (cnt == CW'(LIMIT));
endmodule

// File: rtl/sec_session.sv
module sec_session
    import sec_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             sess_rst,
    input  logic             mac_fail,
    input  logic             pw_take,
    input  logic             pw_pass,
    input  logic             pw_wr,
    input  logic [PW_W-1:0]  pw_set,
    input  logic             au_take,
    input  logic             au_pass,
    input  logic [KEY_W-1:0] au_key,
    input  logic             enc_req,
    output pw_state_t        pw_q,
    output au_state_t        au_q,
    output mode_e            mode_q
);
    logic mac_abort;
    assign mac_abort = mac_fail && mode_secure(mode_q);

    always_ff @(posedge clk) begin
        if (por || sess_rst) begin
            pw_q   <= '0;
            au_q   <= '0;
            mode_q <= MODE_STD;
        end else if (mac_abort) begin
            au_q   <= '0;
            mode_q <= MODE_STD;
        end else begin
            if (pw_take) begin
                if (pw_pass) begin
                    pw_q.valid <= 1'b1;
                    pw_q.set   <= pw_set;
                    pw_q.wr    <= pw_wr;
                end else begin
                    pw_q <= '0;
                end
            end
            if (au_take) begin
                if (au_pass) begin
                    au_q.valid <= 1'b1;
                    au_q.key   <= au_key;
                    mode_q     <= MODE_AUTH;
                end else begin
                    au_q   <= '0;
                    mode_q <= MODE_STD;
                end
            end else if (enc_req && (mode_q == MODE_AUTH)) begin
                mode_q <= MODE_ENC;
            end
        end
    end
endmodule

// File: rtl/sec_zone_gate.sv
module sec_zone_gate
    import sec_pkg::*;
(
    input  zone_cfg_t cfg,
    input  pw_state_t pw_q,
    input  au_state_t au_q,
    input  mode_e     mode_q,
    output logic      rd,
    output logic      wr
);
    logic pw_match, pw_rd_ok, pw_wr_ok, key_match, au_ok, enc_ok;

    always_comb begin
        pw_match  = pw_q.valid && (pw_q.set == cfg.pw_idx);
        pw_rd_ok  = !cfg.pw_en || pw_match;
        pw_wr_ok  = !cfg.pw_en || (pw_match && pw_q.wr);
        key_match = au_q.valid && (au_q.key == cfg.key_idx);
        au_ok     = !cfg.au_en  || (mode_secure(mode_q) && key_match);
        enc_ok    = !cfg.enc_en || ((mode_q == MODE_ENC) && key_match);
        rd        = pw_rd_ok && au_ok && enc_ok;
        wr        = pw_wr_ok && au_ok && enc_ok;
    end
endmodule

// File: rtl/sec_access_tracker.sv
module sec_access_tracker
    import sec_pkg::*;
(
    input  logic                   clk,
    input  logic                   por,
    input  logic                   sess_rst,
    input  logic                   pw_vld,
    input  logic                   pw_pass,
    input  logic                   pw_wr,
    input  logic [PW_W-1:0]        pw_set,
    input  logic                   au_vld,
    input  logic                   au_pass,
    input  logic [KEY_W-1:0]       au_key,
    input  logic                   enc_req,
    input  logic                   mac_fail,
    input  logic [ZONES*CFG_W-1:0] zone_cfg,
    output logic [ZONES-1:0]       rd_grant,
    output logic [ZONES-1:0]       wr_grant,
    output logic [1:0]             mode,
    output logic [PW_SETS-1:0]     pw_locked,
    output logic [KEYS-1:0]        key_locked
);
    pw_state_t pw_q;
    au_state_t au_q;
    mode_e     mode_q;

    logic abort, pw_take, au_take;

    // Higher-priority events swallow the credential verdicts of the cycle.
    assign abort   = sess_rst || (mac_fail && mode_secure(mode_q));
    assign pw_take = pw_vld && !pw_locked[pw_set] && !abort;
    assign au_take = au_vld && !key_locked[au_key] && !abort;

    genvar gi;
    generate
        for (gi = 0; gi < PW_SETS; gi++) begin : g_pw_ctr
            sec_fail_ctr #(.LIMIT(FAIL_LIMIT)) u_ctr (
                .clk      (clk),
                .por      (por),
                .hit_pass (pw_take && pw_pass  && (pw_set == PW_W'(gi))),
                .hit_fail (pw_take && !pw_pass && (pw_set == PW_W'(gi))),
                .locked   (pw_locked[gi])
            );
        end
        for (gi = 0; gi < KEYS; gi++) begin : g_key_ctr
            sec_fail_ctr #(.LIMIT(FAIL_LIMIT)) u_ctr (
                .clk      (clk),
                .por      (por),
                .hit_pass (au_take && au_pass  && (au_key == KEY_W'(gi))),
                .hit_fail (au_take && !au_pass && (au_key == KEY_W'(gi))),
                .locked   (key_locked[gi])
            );
        end
    endgenerate

    sec_session u_sess (
        .clk      (clk),
        .por      (por),
        .sess_rst (sess_rst),
        .mac_fail (mac_fail),
        .pw_take  (pw_take),
        .pw_pass  (pw_pass),
        .pw_wr    (pw_wr),
        .pw_set   (pw_set),
        .au_take  (au_take),
        .au_pass  (au_pass),
        .au_key   (au_key),
        .enc_req  (enc_req),
        .pw_q     (pw_q),
        .au_q     (au_q),
        .mode_q   (mode_q)
    );

    generate
        for (gi = 0; gi < ZONES; gi++) begin : g_zone
            sec_zone_gate u_gate (
                .cfg    (cfg_slice(zone_cfg, gi)),
                .pw_q   (pw_q),
                .au_q   (au_q),
                .mode_q (mode_q),
                .rd     (rd_grant[gi]),
                .wr     (wr_grant[gi])
            );
        end
    endgenerate

    assign mode = mode_q;
endmodule

// File: rtl/sec_access_chk.sv
module sec_access_chk
    import sec_pkg::*;
(
    input logic                 clk,
    input logic                 por,
    input logic                 sess_rst,
    input logic                 mac_fail,
    input logic                 au_vld,
    input logic                 au_pass,
    input logic [KEY_W-1:0]     au_key,
    input logic                 enc_req,
    input logic [1:0]           mode,
    input logic [ZONES-1:0]     rd_grant,
    input logic [ZONES-1:0]     wr_grant,
    input logic [PW_SETS-1:0]   pw_locked,
    input logic [KEYS-1:0]      key_locked
);
    p_wr_needs_rd_r3: assert property (@(posedge clk) disable iff (por)
        (wr_grant & ~rd_grant) == '0);

    p_au_fail_std_r4: assert property (@(posedge clk) disable iff (por)
        (au_vld && !au_pass && !key_locked[au_key] && !sess_rst) |=> (mode == MODE_STD));

    p_enc_from_auth_r5: assert property (@(posedge clk) disable iff (por)
        $rose(mode == MODE_ENC) |-> ($past(mode) == MODE_AUTH));

    p_mac_drop_r6: assert property (@(posedge clk) disable iff (por)
        (mac_fail && (mode != MODE_STD)) |=> (mode == MODE_STD));

    p_sess_rst_std_r7: assert property (@(posedge clk) disable iff (por)
        sess_rst |=> (mode == MODE_STD));

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (por)
        1'b1 |=> ((($past(pw_locked) & ~pw_locked) == '0) &&
                  (($past(key_locked) & ~key_locked) == '0)));

    p_locked_key_ignored_r8: assert property (@(posedge clk) disable iff (por)
        (au_vld && key_locked[au_key] && (mode == MODE_STD) && !enc_req) |=> (mode == MODE_STD));
endmodule

bind sec_access_tracker sec_access_chk u_chk (
    .clk        (clk),
    .por        (por),
    .sess_rst   (sess_rst),
    .mac_fail   (mac_fail),
    .au_vld     (au_vld),
    .au_pass    (au_pass),
    .au_key     (au_key),
    .enc_req    (enc_req),
    .mode       (mode),
    .rd_grant   (rd_grant),
    .wr_grant   (wr_grant),
    .pw_locked  (pw_locked),
    .key_locked (key_locked)
);

// File: tb/sec_access_tracker_test.sv
module sec_access_tracker_test;
    import sec_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                   por = 1'b1;
    logic                   sess_rst = 1'b0;
    logic                   pw_vld = 1'b0, pw_pass = 1'b0, pw_wr = 1'b0;
    logic [PW_W-1:0]        pw_set = '0;
    logic                   au_vld = 1'b0, au_pass = 1'b0;
    logic [KEY_W-1:0]       au_key = '0;
    logic                   enc_req = 1'b0, mac_fail = 1'b0;
    logic [ZONES*CFG_W-1:0] zone_cfg;
    logic [ZONES-1:0]       rd_grant, wr_grant;
    logic [1:0]             mode;
    logic [PW_SETS-1:0]     pw_locked;
    logic [KEYS-1:0]        key_locked;

    // R10 layout: zone0 open, zone1 password set 2, zone2 auth key 1,
    // zone3 auth + encryption key 3.
    assign zone_cfg = {8'h0F, 8'h09, 8'hA0, 8'h00};

    sec_access_tracker uut (
        .clk(clk), .por(por), .sess_rst(sess_rst),
        .pw_vld(pw_vld), .pw_pass(pw_pass), .pw_wr(pw_wr), .pw_set(pw_set),
        .au_vld(au_vld), .au_pass(au_pass), .au_key(au_key),
        .enc_req(enc_req), .mac_fail(mac_fail), .zone_cfg(zone_cfg),
        .rd_grant(rd_grant), .wr_grant(wr_grant), .mode(mode),
        .pw_locked(pw_locked), .key_locked(key_locked)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Fields: pw_vld pw_pass pw_wr set | au_vld au_pass key | enc mac srst | mode rd wr
    localparam int NV = 19;
    localparam logic [22:0] VEC [NV] = '{
        {3'b110, 3'd2, 2'b00, 2'd0, 3'b000, 2'd0, 4'b0011, 4'b0001}, // R3 read pw
        {3'b111, 3'd2, 2'b00, 2'd0, 3'b000, 2'd0, 4'b0011, 4'b0011}, // R3 write pw
        {3'b111, 3'd5, 2'b00, 2'd0, 3'b000, 2'd0, 4'b0001, 4'b0001}, // R2 replace
        {3'b111, 3'd2, 2'b00, 2'd0, 3'b000, 2'd0, 4'b0011, 4'b0011}, // R2
        {3'b100, 3'd2, 2'b00, 2'd0, 3'b000, 2'd0, 4'b0001, 4'b0001}, // R2 fail drops
        {3'b111, 3'd2, 2'b00, 2'd0, 3'b000, 2'd0, 4'b0011, 4'b0011}, // R9 pass after fail
        {3'b000, 3'd0, 2'b11, 2'd1, 3'b000, 2'd1, 4'b0111, 4'b0111}, // R4 auth key1
        {3'b000, 3'd0, 2'b00, 2'd0, 3'b100, 2'd2, 4'b0111, 4'b0111}, // R5 enc
        {3'b000, 3'd0, 2'b00, 2'd0, 3'b010, 2'd0, 4'b0011, 4'b0011}, // R6 mac drop
        {3'b000, 3'd0, 2'b11, 2'd3, 3'b000, 2'd1, 4'b0011, 4'b0011}, // R11 auth key3, no enc
        {3'b000, 3'd0, 2'b00, 2'd0, 3'b100, 2'd2, 4'b1011, 4'b1011}, // R11 enc key3
        {3'b000, 3'd0, 2'b10, 2'd3, 3'b000, 2'd0, 4'b0011, 4'b0011}, // R4 fail forgets
        {3'b000, 3'd0, 2'b00, 2'd0, 3'b100, 2'd0, 4'b0011, 4'b0011}, // R5 enc ignored
        {3'b000, 3'd0, 2'b00, 2'd0, 3'b001, 2'd0, 4'b0001, 4'b0001}, // R7 sess reset
        {3'b000, 3'd0, 2'b11, 2'd1, 3'b010, 2'd1, 4'b0101, 4'b0101}, // R6 mac in std
        {3'b000, 3'd0, 2'b11, 2'd3, 3'b010, 2'd0, 4'b0001, 4'b0001}, // R6 mac wins
        {3'b111, 3'd2, 2'b00, 2'd0, 3'b001, 2'd0, 4'b0001, 4'b0001}, // R7 reset wins
        {3'b000, 3'd0, 2'b11, 2'd1, 3'b100, 2'd1, 4'b0101, 4'b0101}, // R5 auth beats enc
        {3'b000, 3'd0, 2'b00, 2'd0, 3'b100, 2'd2, 4'b0101, 4'b0101}  // R10 enc key1
    };

    task automatic idle();
        pw_vld = 0; pw_pass = 0; pw_wr = 0; pw_set = '0;
        au_vld = 0; au_pass = 0; au_key = '0;
        enc_req = 0; mac_fail = 0; sess_rst = 0;
    endtask

    task automatic pw_try(input logic pass, input logic wr, input int set);
        @(negedge clk);
        pw_vld = 1; pw_pass = pass; pw_wr = wr; pw_set = PW_W'(set);
        @(negedge clk);
        idle();
    endtask

    task automatic au_try(input logic pass, input int key);
        @(negedge clk);
        au_vld = 1; au_pass = pass; au_key = KEY_W'(key);
        @(negedge clk);
        idle();
    endtask

    task automatic do_por();
        @(negedge clk);
        por = 1;
        repeat (2) @(negedge clk);
        por = 0;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        por = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", mode, 0);
        check("R1 rd", rd_grant, 4'b0001);
        check("R1 wr", wr_grant, 4'b0001);
        check("R1 locks", {pw_locked, key_locked}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            @(negedge clk);
            pw_vld = v[22]; pw_pass = v[21]; pw_wr = v[20]; pw_set = v[19:17];
            au_vld = v[16]; au_pass = v[15]; au_key = v[14:13];
            enc_req = v[12]; mac_fail = v[11]; sess_rst = v[10];
            @(negedge clk);
            idle();
            check($sformatf("R10 table step %0d mode", i), mode, int'(v[9:8]));
            check($sformatf("R10 table step %0d rd", i), rd_grant, int'(v[7:4]));
            check($sformatf("R10 table step %0d wr", i), wr_grant, int'(v[3:0]));
        end

        // R8: four consecutive failures lock password set 2
        do_por();
        for (int k = 0; k < 3; k++) pw_try(1'b0, 1'b0, 2);
        check("R8 set2 not locked after 3", pw_locked[2], 0);
        pw_try(1'b0, 1'b0, 2);
        check("R8 set2 locked after 4", pw_locked, 8'h04);
        pw_try(1'b1, 1'b1, 2);
        check("R8 locked set pass ignored rd", rd_grant, 4'b0001);
        check("R8 locked set pass ignored wr", wr_grant, 4'b0001);
        // R7: session reset keeps lock flags
        @(negedge clk); sess_rst = 1; @(negedge clk); idle();
        check("R7 lock survives sess_rst", pw_locked, 8'h04);

        // R9: a success clears the failure count of key 2
        for (int k = 0; k < 3; k++) au_try(1'b0, 2);
        au_try(1'b1, 2);
        check("R9 auth pass mode", mode, 1);
        for (int k = 0; k < 3; k++) au_try(1'b0, 2);
        check("R9 key2 not locked", key_locked, 4'h0);
        au_try(1'b0, 2);
        check("R8 key2 locked", key_locked, 4'h4);
        au_try(1'b1, 2);
        check("R8 locked key pass ignored", mode, 0);

        // R1: power-on reset clears locks
        do_por();
        check("R1 por clears locks", {pw_locked, key_locked}, 0);

        // R11: encrypted with wrong key gives no grant on zone3
        au_try(1'b1, 1);
        @(negedge clk); enc_req = 1; @(negedge clk); idle();
        check("R11 wrong key enc zone3", rd_grant[3], 0);
        check("R5 enc mode", mode, 2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule